// File: doc/BRIEF.md
# Stack Access Queue with Offset Forwarding

This block holds memory operations that have been steered to the local-variable path of a core. Each operation is identified by its byte offset from the current stack pointer, not by a computed address. The offset alone is enough to find its dependences. A load whose offset equals that of a queued store takes the youngest such store's data straight away and never goes to the cache. A load with no match waits its turn and is sent to the cache read port carrying its tag. Stores drain to the local-variable cache in program order. When the two oldest entries are stores to consecutive words in ascending order, they leave as one two-word write.

A stack-pointer change makes every offset already in the queue meaningless for comparison. The block therefore stops using those entries for forwarding and does not merge across the change. The stale entries still retire normally. A cache-port grant input holds retirement back while the port is busy. An enqueue ready signal stops the producer when all entries are taken.

Top module: `stack_access_queue`

## Requirements
- R1: After a synchronous active-low reset the queue is empty: enq_ready is 1 and rd_valid, wr_valid and res_valid are 0.
- R2: A load accepted in cycle t whose offset equals that of a live queued store gives res_valid=1 in cycle t+1, with the load's tag and that store's data. The load takes no queue slot and is never issued on the read port.
- R3: When several live queued stores match a load's offset, the data forwarded is that of the youngest of them.
- R4: A load with no live matching store is queued. When it is the oldest entry and mem_ready is 1, it appears on rd_valid/rd_ofs/rd_tag for one cycle, and it never produces res_valid.
- R5: Entries retire strictly in program order, one per granted cycle. A store retiring alone gives wr_valid=1, wr_pair=0, wr_ofs = its offset, and its data in wr_data[31:0].
- R6: If the oldest two entries are both stores, and the second one's offset is the first one's plus 4 (offsets are byte offsets, a word is 4 bytes), they retire together in one cycle. The write shows wr_pair=1 and wr_ofs = the lower offset, with the lower store's data in wr_data[31:0] and the upper store's data in wr_data[63:32]. This applies unless a stack-pointer change arrived between the two stores.
- R7: A write never covers more than two stores: three ascending adjacent stores retire as a pair and then a single write.
- R8: No merge happens for equal offsets, for descending offsets, or for two stores that have a load between them.
- R9: When sp_change is 1 in a cycle, every entry already queued is excluded from forwarding, including for a load enqueued in that same cycle. The entry enqueued in that cycle, or the first one enqueued after it, is never merged with the entry ahead of it.
- R10: With 8 entries held, enq_ready is 0 and an offered operation is not taken.
- R11: While mem_ready is 0, rd_valid and wr_valid are 0 and nothing retires. rd_valid and wr_valid are never both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| sp_change | input | 1 | Stack pointer changed this cycle |
| enq_valid | input | 1 | Operation offered |
| enq_ready | output | 1 | Queue can take an operation |
| enq_store | input | 1 | 1 = store, 0 = load |
| enq_ofs | input | 8 | Word-aligned byte offset from the stack pointer |
| enq_data | input | 32 | Store data |
| enq_tag | input | 4 | Load tag |
| mem_ready | input | 1 | Cache port granted this cycle |
| rd_valid | output | 1 | Load issued to the cache |
| rd_ofs | output | 8 | Offset of the issued load |
| rd_tag | output | 4 | Tag of the issued load |
| wr_valid | output | 1 | Store write issued to the cache |
| wr_pair | output | 1 | Write covers two consecutive words |
| wr_ofs | output | 8 | Offset of the lower word written |
| wr_data | output | 64 | Write data, lower word in bits 31:0 |
| res_valid | output | 1 | Forwarded load result |
| res_tag | output | 4 | Tag of the forwarded load |
| res_data | output | 32 | Forwarded data |

## Verification
A wrong head pointer, count or live bit shows up at the ports almost at once. A stale or misordered entry changes the offset, data or pair flag on the very next granted write or read. A live bit left set after a stack-pointer change shows up as a spurious res_valid one cycle after the next load to that offset. A bench-side model of the queue predicts every port value on every cycle, so a divergence is caught in the cycle it first reaches a port. A long mixed sweep over four offsets drives the queue repeatedly through full, merge and forwarding situations.

// File: rtl/sq_pkg.sv
// Shared widths and the queue entry layout for the stack access queue.
// Assumes offsets are byte offsets that are multiples of 4.
package sq_pkg;
    localparam int OFS_W  = 8;
    localparam int DATA_W = 32;
    localparam int TAG_W  = 4;
    localparam int WORD_B = 4;

    typedef struct packed {
        logic              store;  // 1 = store, 0 = load
        logic              live;   // offset still comparable under current SP
        logic              brk;    // first entry after an SP change
        logic [OFS_W-1:0]  ofs;
        logic [DATA_W-1:0] data;
        logic [TAG_W-1:0]  tag;
    } sq_entry_t;
endpackage

// File: rtl/stq_fwd_lookup.sv
// Searches the queued entries for live stores whose offset equals the
// lookup offset and returns the youngest one's data. Assumes entries
// are held in a circular buffer addressed from head, count entries long.
module stq_fwd_lookup
    import sq_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  sq_entry_t [DEPTH-1:0] ents,
    input  logic [PTR_W-1:0]      head,
    input  logic [CNT_W-1:0]      count,
    input  logic [OFS_W-1:0]      ofs,
    input  logic                  kill,
    output logic                  hit,
    output logic [DATA_W-1:0]     data
);
    sq_entry_t [DEPTH-1:0] by_age;
    logic      [DEPTH-1:0] match;

    // Per-age match flags, index 0 is the oldest entry.
    for (genvar g = 0; g < DEPTH; g++) begin : g_age
        assign by_age[g] = ents[head + PTR_W'(g)];
        assign match[g]  = (CNT_W'(g) < count) && by_age[g].store &&
                           by_age[g].live && (by_age[g].ofs == ofs);
    end

    // Youngest match wins; an SP change this cycle suppresses all.
    always_comb begin
        hit  = 1'b0;
        data = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (match[i]) begin
                hit  = 1'b1;
                data = by_age[i].data;
            end
        end
        if (kill) begin
            hit  = 1'b0;
            data = '0;
        end
    end
endmodule

// File: rtl/stq_retire.sv
// Decides what the oldest entry does when the cache port is granted: a
// load goes to the read port, a store to the write port, and two
// ascending word-adjacent stores from one SP epoch share one write.
module stq_retire
    import sq_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  sq_entry_t           head_e,
    input  sq_entry_t           next_e,
    input  logic [CNT_W-1:0]    count,
    input  logic                mem_ready,
    output logic                rd_valid,
    output logic [OFS_W-1:0]    rd_ofs,
    output logic [TAG_W-1:0]    rd_tag,
    output logic                wr_valid,
    output logic                wr_pair,
    output logic [OFS_W-1:0]    wr_ofs,
    output logic [2*DATA_W-1:0] wr_data,
    output logic [1:0]          pop_n
);
    logic go;
    logic adjacent;

    // Upper store must sit one word above the lower, without wrapping.
    assign adjacent = ({1'b0, head_e.ofs} + (OFS_W + 1)'(WORD_B)) == {1'b0, next_e.ofs};
    assign go       = mem_ready && (count != '0);

    // Port selection and pop count for this cycle.
    always_comb begin
        rd_valid = go && !head_e.store;
        wr_valid = go && head_e.store;
        wr_pair  = wr_valid && (count >= CNT_W'(2)) && next_e.store &&
                   !next_e.brk && adjacent;
        rd_ofs   = head_e.ofs;
        rd_tag   = head_e.tag;
        wr_ofs   = head_e.ofs;
        wr_data  = {wr_pair ? next_e.data : {DATA_W{1'b0}}, head_e.data};
        pop_n    = wr_pair ? 2'd2 : (go ? 2'd1 : 2'd0);
    end
endmodule

// File: rtl/stack_access_queue.sv
// Stack access queue: an in-order circular buffer of stack-relative
// loads and stores. Loads are forwarded from the youngest live store at
// enqueue; the rest drain in order through one cache port per cycle.
// Assumes offsets are word aligned and one enqueue per cycle at most.
module stack_access_queue
    import sq_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                sp_change,
    input  logic                enq_valid,
    output logic                enq_ready,
    input  logic                enq_store,
    input  logic [OFS_W-1:0]    enq_ofs,
    input  logic [DATA_W-1:0]   enq_data,
    input  logic [TAG_W-1:0]    enq_tag,
    input  logic                mem_ready,
    output logic                rd_valid,
    output logic [OFS_W-1:0]    rd_ofs,
    output logic [TAG_W-1:0]    rd_tag,
    output logic                wr_valid,
    output logic                wr_pair,
    output logic [OFS_W-1:0]    wr_ofs,
    output logic [2*DATA_W-1:0] wr_data,
    output logic                res_valid,
    output logic [TAG_W-1:0]    res_tag,
    output logic [DATA_W-1:0]   res_data
);
    sq_entry_t [DEPTH-1:0] q_mem;
    logic [PTR_W-1:0]      head_q;
    logic [CNT_W-1:0]      count_q;
    logic                  pend_brk_q;
    logic                  fwd_hit;
    logic [DATA_W-1:0]     fwd_data;
    logic [1:0]            pop_n;
    logic                  accept;
    logic                  alloc;
    logic [PTR_W-1:0]      tail;

    assign enq_ready = (count_q < CNT_W'(DEPTH));
    assign accept    = enq_valid && enq_ready;
    assign alloc     = accept && (enq_store || !fwd_hit);
    assign tail      = head_q + count_q[PTR_W-1:0];

    stq_fwd_lookup #(.DEPTH(DEPTH)) u_lookup (
        .ents  (q_mem),
        .head  (head_q),
        .count (count_q),
        .ofs   (enq_ofs),
        .kill  (sp_change),
        .hit   (fwd_hit),
        .data  (fwd_data)
    );

    stq_retire #(.DEPTH(DEPTH)) u_retire (
        .head_e    (q_mem[head_q]),
        .next_e    (q_mem[head_q + PTR_W'(1)]),
        .count     (count_q),
        .mem_ready (mem_ready),
        .rd_valid  (rd_valid),
        .rd_ofs    (rd_ofs),
        .rd_tag    (rd_tag),
        .wr_valid  (wr_valid),
        .wr_pair   (wr_pair),
        .wr_ofs    (wr_ofs),
        .wr_data   (wr_data),
        .pop_n     (pop_n)
    );

    // Entry storage: SP change retires liveness, new entry written at tail.
    always_ff @(posedge clk) begin
        if (sp_change) begin
            for (int i = 0; i < DEPTH; i++) begin
                q_mem[i].live <= 1'b0;
            end
        end
        if (alloc) begin
            q_mem[tail] <= '{store: enq_store, live: 1'b1,
                             brk: sp_change || pend_brk_q, ofs: enq_ofs,
                             data: enq_data, tag: enq_tag};
        end
    end

    // Pointer, occupancy and pending-break bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            head_q     <= '0;
            count_q    <= '0;
            pend_brk_q <= 1'b0;
        end else begin
            head_q     <= head_q + PTR_W'(pop_n);
            count_q    <= count_q + CNT_W'(alloc) - CNT_W'(pop_n);
            if (alloc) begin
                pend_brk_q <= 1'b0;
            end else if (sp_change) begin
                pend_brk_q <= 1'b1;
            end
        end
    end

    // Forwarded load result, one cycle after the load is offered.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_valid <= 1'b0;
            res_tag   <= '0;
            res_data  <= '0;
        end else begin
            res_valid <= accept && !enq_store && fwd_hit;
            res_tag   <= enq_tag;
            res_data  <= fwd_data;
        end
    end

    p_count_bound_r10: assert property (@(posedge clk) disable iff (!rst_n)
        count_q <= CNT_W'(DEPTH));

    p_full_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (count_q == CNT_W'(DEPTH) && !wr_valid && !rd_valid)
            |=> (count_q == CNT_W'(DEPTH)));

    p_port_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({wr_valid, rd_valid}));

    p_no_grant_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_ready |-> (!wr_valid && !rd_valid));

    p_res_from_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> $past(enq_valid && enq_ready && !enq_store));

    p_pair_needs_two_r6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_pair |-> (count_q >= CNT_W'(2)));
endmodule

// File: tb/stack_access_queue_tb_top.sv
`timescale 1ns/1ps
module stack_access_queue_tb_top;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        sp_change, enq_valid, enq_store, mem_ready;
    logic [7:0]  enq_ofs;
    logic [31:0] enq_data;
    logic [3:0]  enq_tag;
    logic        enq_ready, rd_valid, wr_valid, wr_pair, res_valid;
    logic [7:0]  rd_ofs, wr_ofs;
    logic [3:0]  rd_tag, res_tag;
    logic [63:0] wr_data;
    logic [31:0] res_data;

    int nvec = 0;
    int nfail = 0;

    // Bench model of the queue, index 0 is the oldest entry.
    int          mcount = 0;
    logic        mst[8], mlive[8], mbrk[8];
    logic [7:0]  mofs[8];
    logic [31:0] mdat[8];
    logic [3:0]  mtag[8];
    logic        mpend = 1'b0;
    logic        mres_v = 1'b0;
    logic [3:0]  mres_tag;
    logic [31:0] mres_dat;
    logic [31:0] lfsr = 32'h1234_5678;

    always #2 clk = ~clk;

    stack_access_queue dut_i (
        .clk(clk), .rst_n(rst_n), .sp_change(sp_change),
        .enq_valid(enq_valid), .enq_ready(enq_ready), .enq_store(enq_store),
        .enq_ofs(enq_ofs), .enq_data(enq_data), .enq_tag(enq_tag),
        .mem_ready(mem_ready), .rd_valid(rd_valid), .rd_ofs(rd_ofs),
        .rd_tag(rd_tag), .wr_valid(wr_valid), .wr_pair(wr_pair),
        .wr_ofs(wr_ofs), .wr_data(wr_data), .res_valid(res_valid),
        .res_tag(res_tag), .res_data(res_data)
    );

    task automatic chk(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        nvec++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // One cycle: drive at negedge, predict and compare, then advance the model.
    task automatic step(input logic v, input logic st, input logic [7:0] ofs,
                        input logic [31:0] d, input logic [3:0] tag,
                        input logic sp, input logic mr);
        logic e_ready, acc, e_wr, e_pair, e_rd, hit;
        logic [31:0] hd;
        int pop;
        enq_valid = v; enq_store = st; enq_ofs = ofs; enq_data = d;
        enq_tag = tag; sp_change = sp; mem_ready = mr;
        #1;
        e_ready = (mcount < 8);
        acc = v && e_ready;
        e_wr = 0; e_pair = 0; e_rd = 0; pop = 0; hit = 0; hd = '0;
        if (mr && mcount > 0) begin
            if (mst[0]) begin
                e_wr = 1;
                if (mcount >= 2 && mst[1] && !mbrk[1] &&
                    int'(mofs[1]) == int'(mofs[0]) + 4) e_pair = 1;
                pop = e_pair ? 2 : 1;
            end else begin
                e_rd = 1; pop = 1;
            end
        end
        if (acc && !st && !sp) begin
            for (int i = 0; i < mcount; i++) begin
                if (mst[i] && mlive[i] && mofs[i] == ofs) begin
                    hit = 1; hd = mdat[i];
                end
            end
        end
        chk("R10", "enq_ready", 64'(enq_ready), 64'(e_ready));
        chk("R2", "res_valid", 64'(res_valid), 64'(mres_v));
        if (mres_v) begin
            chk("R2", "res_tag", 64'(res_tag), 64'(mres_tag));
            chk("R3", "res_data", 64'(res_data), 64'(mres_dat));
        end
        chk("R5", "wr_valid", 64'(wr_valid), 64'(e_wr));
        chk("R4", "rd_valid", 64'(rd_valid), 64'(e_rd));
        if (e_wr) begin
            chk("R6", "wr_pair", 64'(wr_pair), 64'(e_pair));
            chk("R5", "wr_ofs", 64'(wr_ofs), 64'(mofs[0]));
            chk("R5", "wr_data_lo", 64'(wr_data[31:0]), 64'(mdat[0]));
            if (e_pair) chk("R6", "wr_data_hi", 64'(wr_data[63:32]), 64'(mdat[1]));
        end
        if (e_rd) begin
            chk("R4", "rd_ofs", 64'(rd_ofs), 64'(mofs[0]));
            chk("R4", "rd_tag", 64'(rd_tag), 64'(mtag[0]));
        end
        @(posedge clk);
        for (int p = 0; p < pop; p++) begin
            for (int i = 0; i < 7; i++) begin
                mst[i] = mst[i+1]; mlive[i] = mlive[i+1]; mbrk[i] = mbrk[i+1];
                mofs[i] = mofs[i+1]; mdat[i] = mdat[i+1]; mtag[i] = mtag[i+1];
            end
            mcount--;
        end
        if (sp) for (int i = 0; i < 8; i++) mlive[i] = 1'b0;
        if (acc && (st || !hit)) begin
            mst[mcount] = st; mlive[mcount] = 1'b1; mbrk[mcount] = sp || mpend;
            mofs[mcount] = ofs; mdat[mcount] = d; mtag[mcount] = tag;
            mcount++;
            mpend = 1'b0;
        end else if (sp) begin
            mpend = 1'b1;
        end
        mres_v = acc && !st && hit; mres_tag = tag; mres_dat = hd;
        @(negedge clk);
    endtask

    task automatic idle(input logic mr, input int n);
        for (int k = 0; k < n; k++) step(0, 0, 8'h0, 32'h0, 4'h0, 0, mr);
    endtask

    initial begin
        #800000;
        nfail++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end

    initial begin
        rst_n = 0; sp_change = 0; enq_valid = 0; enq_store = 0; enq_ofs = 0;
        enq_data = 0; enq_tag = 0; mem_ready = 1;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1; #1;
        // R1: empty after reset
        chk("R1", "enq_ready", 64'(enq_ready), 64'd1);
        chk("R1", "wr_valid", 64'(wr_valid), 64'd0);
        chk("R1", "rd_valid", 64'(rd_valid), 64'd0);
        chk("R1", "res_valid", 64'(res_valid), 64'd0);
        @(negedge clk);

        // R2, R3: two stores at 8, load at 8 gets the younger; load at 12 misses (R4)
        step(1, 1, 8'd8, 32'hAAAA_0001, 4'h0, 0, 0);
        step(1, 1, 8'd8, 32'hBBBB_0002, 4'h0, 0, 0);
        step(1, 0, 8'd8, 32'h0, 4'h3, 0, 0);
        step(1, 0, 8'd12, 32'h0, 4'h5, 0, 0);
        idle(0, 2);               // R11: no grant, nothing retires
        idle(1, 4);               // R8: equal offsets do not merge

        // R6, R7: three ascending adjacent stores -> pair then single
        step(1, 1, 8'd4, 32'h0000_0004, 4'h0, 0, 0);
        step(1, 1, 8'd8, 32'h0000_0008, 4'h0, 0, 0);
        step(1, 1, 8'd12, 32'h0000_000C, 4'h0, 0, 0);
        idle(1, 3);

        // R8: descending, and store-load-store, do not merge
        step(1, 1, 8'd8, 32'h1, 4'h0, 0, 0);
        step(1, 1, 8'd4, 32'h2, 4'h0, 0, 0);
        step(1, 1, 8'd16, 32'h3, 4'h0, 0, 0);
        step(1, 0, 8'd40, 32'h0, 4'h7, 0, 0);
        step(1, 1, 8'd20, 32'h4, 4'h0, 0, 0);
        idle(1, 6);

        // R9: SP change kills forwarding and breaks merging
        step(1, 1, 8'd16, 32'h5, 4'h0, 0, 0);
        step(1, 0, 8'd16, 32'h0, 4'h9, 1, 0);   // same-cycle load: no forward
        step(1, 0, 8'd16, 32'h0, 4'hA, 0, 0);   // later load: no forward
        step(0, 0, 8'd0, 32'h0, 4'h0, 1, 0);
        step(1, 1, 8'd20, 32'h6, 4'h0, 0, 0);
        step(1, 1, 8'd24, 32'h7, 4'h0, 0, 0);
        step(1, 0, 8'd24, 32'h0, 4'hB, 0, 0);   // forwards from live store
        idle(1, 8);
        step(1, 1, 8'd28, 32'h8, 4'h0, 0, 0);
        step(1, 1, 8'd32, 32'h9, 4'h0, 1, 0);   // brk set: no pair with 28
        idle(1, 4);

        // R10: fill 8 entries, ninth offered operation is refused
        for (int i = 0; i < 9; i++)
            step(1, 1, 8'(i * 8), 32'hF000_0000 + 32'(i), 4'h0, 0, 0);
        step(1, 0, 8'd0, 32'h0, 4'hC, 0, 0);
        idle(1, 10);

        // Sweep: mixed traffic over four offsets
        for (int k = 0; k < 6000; k++) begin
            lfsr = lfsr ^ (lfsr << 13); lfsr = lfsr ^ (lfsr >> 17);
            lfsr = lfsr ^ (lfsr << 5);
            step(lfsr[0] | lfsr[1], lfsr[2], {4'b0, lfsr[5:4], 2'b00},
                 lfsr ^ 32'h5A5A_0000, lfsr[11:8], lfsr[15:12] == 4'h0,
                 lfsr[16]);
        end
        idle(1, 12);

        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end
endmodule